// File: doc/BRIEF.md
# Two-Bank Data Memory Decoder

This block sits in front of the data memory of a small 8-bit core. Each access presents a 7-bit offset from the instruction and a single bank bit taken from the status register. The two are joined into a 9-bit-free, 8-bit linear address with the bank bit on top. The decoder then places that address in one of four regions: a special-function register window, general-purpose RAM, a mirror that reaches back into bank 0's RAM, or empty space.

The general-purpose RAM lives inside the block. Bank 0 owns a large RAM window. Bank 1 owns a smaller RAM window and a 16-byte range that maps onto the top of bank 0's RAM. The lowest 32 offsets of each bank are passed to an external special-function register file through a select strobe and a 6-bit register address that includes the bank bit. Reads of empty space return zero, and writes to it are dropped.

Reads are combinational from the address. Writes commit on the rising clock edge while the write enable is high.

Top module: `bankmem_decoder`

## Requirements
- R1: The linear address is {bank_sel, addr[6:0]}. bank_sel=0 selects bank 0 and bank_sel=1 selects bank 1, so the same offset in the two banks names different locations except where R5 says otherwise.
- R2: For offsets 00h-1Fh in either bank, sfr_sel is 1 and sfr_addr = {bank_sel, addr[4:0]}, with bit 5 holding the bank. rd_data equals sfr_rdata. sfr_wr follows wr_en and sfr_wdata carries wr_data. For every other offset, sfr_sel and sfr_wr are 0.
- R3: Bank 0 offsets 20h-7Fh are read/write RAM. A write followed by a read at the same address returns the written byte.
- R4: Bank 1 offsets 20h-3Fh (linear A0h-BFh) are read/write RAM. This storage is separate from every bank 0 location.
- R5: Bank 1 offsets 70h-7Fh (linear F0h-FFh) reach the same bytes as bank 0 offsets 70h-7Fh, in both directions.
- R6: Bank 1 offsets 40h-6Fh (linear C0h-EFh) are unimplemented. They read as 00h.
- R7: A write to an unimplemented location changes no RAM byte, and no SFR write strobe is raised for it.
- R8: A RAM write takes effect at the rising clock edge while wr_en=1. Before that edge, rd_data still shows the old value.
- R9: After reset, every RAM byte reads 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, clears RAM |
| bank_sel | input | 1 | Bank bit (0 = bank 0, 1 = bank 1) |
| addr | input | 7 | Offset within the bank |
| wr_en | input | 1 | Write enable |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Combinational read data |
| sfr_sel | output | 1 | Special-function window hit |
| sfr_addr | output | 6 | {bank, offset[4:0]} for the external register file |
| sfr_wr | output | 1 | Write strobe to the external register file |
| sfr_wdata | output | 8 | Write data to the external register file |
| sfr_rdata | input | 8 | Read data from the external register file |

## Verification
A wrong decode or a wrong RAM index shows up at rd_data on the next read of the affected address. A write that lands at a wrong index, or a mirror that maps to the wrong byte, only shows up when the victim address is read later, possibly many accesses afterwards. For that reason the bench keeps a model of all 256 linear addresses and scans every one of them at the end. A leaked write into empty space, or a RAM write triggered by an SFR access, is therefore caught even when the corrupted byte was never read during the directed tests. Wrong SFR routing appears at once, in the same cycle, on sfr_sel, sfr_addr or sfr_wr.

// File: rtl/bmd_pkg.sv
package bmd_pkg;
    typedef enum logic [1:0] {
        RGN_SFR  = 2'd0,
        RGN_RAM  = 2'd1,
        RGN_NONE = 2'd2
    } region_e;
endpackage

// File: rtl/bmd_addr_decode.sv
module bmd_addr_decode
    import bmd_pkg::*;
#(
    parameter int OFF_W    = 7,
    parameter int SFR_SPAN = 32,
    parameter int B0_LO    = 32,
    parameter int B0_HI    = 127,
    parameter int B1_LO    = 32,
    parameter int B1_HI    = 63,
    parameter int MIR_LO   = 112,
    parameter int MIR_HI   = 127,
    parameter int IDX_W    = 7
) (
    input  logic             bank,
    input  logic [OFF_W-1:0] off,
    output region_e          rgn,
    output logic [IDX_W-1:0] ram_idx
);
    localparam int B0_SIZE = B0_HI - B0_LO + 1;

    // Region and RAM index for one access.
    always_comb begin
        int o;
        o       = int'(off);
        rgn     = RGN_NONE;
        ram_idx = '0;
        if (o < SFR_SPAN) begin
            rgn = RGN_SFR;
        end else if (!bank) begin
            if (o >= B0_LO && o <= B0_HI) begin
                rgn     = RGN_RAM;
                ram_idx = IDX_W'(o - B0_LO);
            end
        end else if (o >= B1_LO && o <= B1_HI) begin
            // Bank 1's own RAM sits above bank 0's RAM in the array.
            rgn     = RGN_RAM;
            ram_idx = IDX_W'(B0_SIZE + o - B1_LO);
        end else if (o >= MIR_LO && o <= MIR_HI) begin
            // Mirror: the bank 0 byte at the same offset (R5).
            rgn     = RGN_RAM;
            ram_idx = IDX_W'(o - B0_LO);
        end
    end
endmodule

// File: rtl/bmd_gpr_store.sv
module bmd_gpr_store #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 128,
    parameter int IDX_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] mem;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) begin
            st_d.mem[idx] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata = st_q.mem[idx];

    // R8: a write lands at the addressed byte on the edge.
    assert_write_lands_R8: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> st_q.mem[$past(idx)] == $past(wdata));

    // R7: with no write enable, nothing in the array moves.
    assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(st_q));
endmodule

// File: rtl/bmd_read_mux.sv
module bmd_read_mux
    import bmd_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  region_e           rgn,
    input  logic [DATA_W-1:0] sfr_rdata,
    input  logic [DATA_W-1:0] ram_rdata,
    output logic [DATA_W-1:0] rd_data
);
    always_comb begin
        unique case (rgn)
            RGN_SFR: rd_data = sfr_rdata;
            RGN_RAM: rd_data = ram_rdata;
            default: rd_data = '0;
        endcase
    end
endmodule

// File: rtl/bankmem_decoder.sv
module bankmem_decoder
    import bmd_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int OFF_W    = 7,
    parameter int SFR_SPAN = 32,
    parameter int B0_LO    = 32,
    parameter int B0_HI    = 127,
    parameter int B1_LO    = 32,
    parameter int B1_HI    = 63,
    parameter int MIR_LO   = 112,
    parameter int MIR_HI   = 127,
    parameter int SFR_W    = $clog2(SFR_SPAN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bank_sel,
    input  logic [OFF_W-1:0]  addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              sfr_sel,
    output logic [SFR_W:0]    sfr_addr,
    output logic              sfr_wr,
    output logic [DATA_W-1:0] sfr_wdata,
    input  logic [DATA_W-1:0] sfr_rdata
);
    localparam int DEPTH = (B0_HI - B0_LO + 1) + (B1_HI - B1_LO + 1);
    localparam int IDX_W = $clog2(DEPTH);

    region_e           rgn;
    logic [IDX_W-1:0]  ram_idx;
    logic [DATA_W-1:0] ram_rdata;
    logic              ram_we;

    bmd_addr_decode #(
        .OFF_W(OFF_W), .SFR_SPAN(SFR_SPAN),
        .B0_LO(B0_LO), .B0_HI(B0_HI), .B1_LO(B1_LO), .B1_HI(B1_HI),
        .MIR_LO(MIR_LO), .MIR_HI(MIR_HI), .IDX_W(IDX_W)
    ) dec_i (
        .bank(bank_sel), .off(addr), .rgn(rgn), .ram_idx(ram_idx)
    );

    assign ram_we = wr_en && (rgn == RGN_RAM);

    bmd_gpr_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .IDX_W(IDX_W)) store_i (
        .clk(clk), .rst_n(rst_n), .we(ram_we), .idx(ram_idx),
        .wdata(wr_data), .rdata(ram_rdata)
    );

    bmd_read_mux #(.DATA_W(DATA_W)) mux_i (
        .rgn(rgn), .sfr_rdata(sfr_rdata), .ram_rdata(ram_rdata), .rd_data(rd_data)
    );

    assign sfr_sel   = (rgn == RGN_SFR);
    assign sfr_addr  = {bank_sel, addr[SFR_W-1:0]};
    assign sfr_wr    = wr_en && sfr_sel;
    assign sfr_wdata = wr_data;

    // R6: empty space always reads zero.
    assert_hole_reads_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rgn == RGN_NONE) |-> rd_data == '0);

    // R2: the SFR window returns the external register data.
    assert_sfr_passthru_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sfr_sel |-> rd_data == sfr_rdata);

    // R7: a write outside RAM never reaches the array.
    assert_no_stray_ram_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rgn != RGN_RAM) |-> !ram_we);

    // R2: the SFR window never starts at or above the RAM base.
    assert_sfr_window_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sfr_sel |-> int'(addr) < SFR_SPAN);
endmodule

// File: tb/bankmem_decoder_tb_top.sv
module bankmem_decoder_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bank_sel = 1'b0;
    logic [6:0] addr = '0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       sfr_sel;
    logic [5:0] sfr_addr;
    logic       sfr_wr;
    logic [7:0] sfr_wdata;
    logic [7:0] sfr_rdata = 8'hC3;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;
    logic [7:0] model [256];

    always #10 clk = ~clk;   // 50 MHz

    bankmem_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .bank_sel(bank_sel), .addr(addr),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .sfr_sel(sfr_sel), .sfr_addr(sfr_addr), .sfr_wr(sfr_wr),
        .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata)
    );

    // Vector fields: {we, bank, offset[6:0], wdata[7:0], expected[7:0]}
    localparam int NV = 16;
    localparam logic [24:0] VEC [NV] = '{
        {1'b1, 1'b0, 7'h20, 8'h11, 8'h00},  // R3
        {1'b0, 1'b0, 7'h20, 8'h00, 8'h11},  // R3
        {1'b1, 1'b0, 7'h7F, 8'h22, 8'h00},  // R3
        {1'b0, 1'b0, 7'h7F, 8'h00, 8'h22},  // R3
        {1'b1, 1'b1, 7'h20, 8'h33, 8'h00},  // R4
        {1'b0, 1'b1, 7'h20, 8'h00, 8'h33},  // R4
        {1'b0, 1'b0, 7'h20, 8'h00, 8'h11},  // R4 / R1 banks distinct
        {1'b1, 1'b1, 7'h75, 8'h44, 8'h00},  // R5
        {1'b0, 1'b0, 7'h75, 8'h00, 8'h44},  // R5
        {1'b1, 1'b0, 7'h7A, 8'h55, 8'h00},  // R5
        {1'b0, 1'b1, 7'h7A, 8'h00, 8'h55},  // R5
        {1'b1, 1'b1, 7'h50, 8'h66, 8'h00},  // R7
        {1'b0, 1'b1, 7'h50, 8'h00, 8'h00},  // R6
        {1'b0, 1'b1, 7'h3F, 8'h00, 8'h00},  // R9
        {1'b0, 1'b0, 7'h3F, 8'h00, 8'h00},  // R9
        {1'b0, 1'b1, 7'h40, 8'h00, 8'h00}   // R6
    };
    localparam int VREQ [NV] = '{3,3,3,3,4,4,4,5,5,5,5,7,6,9,9,6};

    function automatic logic [7:0] canon(input logic [7:0] lin);
        return (lin >= 8'hF0) ? lin - 8'h80 : lin;
    endfunction

    function automatic bit is_ram(input logic [7:0] lin);
        if (lin[6:0] < 7'h20) return 1'b0;
        if (!lin[7]) return 1'b1;
        return (lin[6:0] <= 7'h3F) || (lin[6:0] >= 7'h70);
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic b, input logic [6:0] a, input logic [7:0] d);
        @(negedge clk);
        bank_sel = b; addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        if (is_ram({b, a})) model[canon({b, a})] = d;
    endtask

    task automatic do_read(input logic b, input logic [6:0] a);
        @(negedge clk);
        bank_sel = b; addr = a; wr_en = 1'b0;
        #2;
    endtask

    initial begin
        for (int i = 0; i < 256; i++) model[i] = 8'h00;
        #35 rst_n = 1'b1;

        // Reset state, R9
        do_read(1'b0, 7'h40); check("R9", rd_data, 8'h00);
        do_read(1'b1, 7'h2A); check("R9", rd_data, 8'h00);
        do_read(1'b1, 7'h7F); check("R9", rd_data, 8'h00);

        // Vector table
        for (int v = 0; v < NV; v++) begin
            string rq;
            rq = $sformatf("R%0d", VREQ[v]);
            if (VEC[v][24]) begin
                do_write(VEC[v][23], VEC[v][22:16], VEC[v][15:8]);
            end else begin
                do_read(VEC[v][23], VEC[v][22:16]);
                check(rq, rd_data, VEC[v][7:0]);
            end
        end

        // R2: SFR window, bank bit in sfr_addr
        do_read(1'b1, 7'h05);
        check("R2", {7'd0, sfr_sel}, 8'h01);
        check("R2", {2'd0, sfr_addr}, 8'h25);
        check("R2", rd_data, 8'hC3);
        sfr_rdata = 8'h3C;
        #1 check("R2", rd_data, 8'h3C);
        do_read(1'b0, 7'h1F);
        check("R1", {2'd0, sfr_addr}, 8'h1F);
        do_read(1'b0, 7'h20);
        check("R2", {7'd0, sfr_sel}, 8'h00);
        @(negedge clk);
        bank_sel = 1'b0; addr = 7'h03; wr_data = 8'h9D; wr_en = 1'b1;
        #2;
        check("R2", {7'd0, sfr_wr}, 8'h01);
        check("R2", sfr_wdata, 8'h9D);
        @(negedge clk); wr_en = 1'b0;

        // R7: write to a hole, no SFR strobe, reads zero
        @(negedge clk);
        bank_sel = 1'b1; addr = 7'h60; wr_data = 8'hEE; wr_en = 1'b1;
        #2 check("R7", {7'd0, sfr_wr}, 8'h00);
        @(negedge clk); wr_en = 1'b0;
        #2 check("R6", rd_data, 8'h00);

        // R8: old value before the edge, new one after
        @(negedge clk);
        bank_sel = 1'b0; addr = 7'h30; wr_data = 8'hA7; wr_en = 1'b1;
        #2 check("R8", rd_data, 8'h00);
        @(posedge clk); #2;
        check("R8", rd_data, 8'hA7);
        @(negedge clk); wr_en = 1'b0;
        model[8'h30] = 8'hA7;

        // Full scan of every linear address against the model
        for (int i = 0; i < 256; i++) begin
            logic [7:0] lin;
            lin = 8'(i);
            do_read(lin[7], lin[6:0]);
            if (lin[6:0] < 7'h20)      check("R2", rd_data, sfr_rdata);
            else if (is_ram(lin))      check("R5", rd_data, model[canon(lin)]);
            else                       check("R6", rd_data, 8'h00);
        end

        // R9: reset again clears RAM
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        do_read(1'b0, 7'h20); check("R9", rd_data, 8'h00);
        do_read(1'b1, 7'h20); check("R9", rd_data, 8'h00);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule